// File: doc/BRIEF.md
# Flash Program/Erase Status Read Path

This block is the read-side status logic of a flash-style memory while an embedded program or sector-erase operation is running. A small state machine tracks whether the memory is idle, programming, erasing or holding an erase in suspension. A down-counter stands in for the internal operation time. While an operation runs, reads return a status word instead of array data. That word carries a polarity bit on bit 7 and a bit on bit 6 that changes with every read. An open-drain ready/busy line is held low at the same time.

During an erase suspension, reads aimed at the suspended sector return a word whose bit 2 changes with every such read. Reads of any other sector pass array data straight through. When the operation ends, every read returns array data. The array, the erase algorithm and supply sensing sit outside this block. Array data arrives on `arr_data`, and the read result is registered on `rd_data` at the clock edge where `rd_stb` is high.

Top module: `flash_status_rpt`

## Requirements
- R1: While `rst` is high and after it, the block is idle: `rd_data` is 0 and `rdy_bsy_n` is not driven low (high-impedance, pulled high externally).
- R2: While a program runs, a read returns the inverse of bit 7 of the programmed word on bit 7.
- R3: While an erase runs (not suspended), a read returns 0 on bit 7.
- R4: While a program or erase runs, bit 6 of a read is 0 on the first read after reset and inverts on every later read whose strobe falls while the operation runs. All bits other than 7 and 6 read 0.
- R5: `rdy_bsy_n` is driven 0 for exactly PROG_CYCLES clock cycles after a program start. It is high-impedance otherwise, including during suspension.
- R6: After completion, reads return `arr_data` unchanged and bit 6 no longer inverts.
- R7: During suspension, a read of the suspended sector returns 0 on every bit except bit 2. Bit 2 starts at 0 after reset and inverts on every such read.
- R8: During suspension, a read of another sector returns `arr_data` and leaves the bit 2 sequence of the suspended sector unchanged.
- R9: An erase holds `rdy_bsy_n` low for a total of ERASE_CYCLES cycles, whether or not it is suspended and resumed. The suspend edge consumes one count and the remaining time is frozen while suspended.
- R10: A program or erase start is ignored unless the block is idle. A suspend is ignored outside an erase, and a resume is ignored outside a suspension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_prog | input | 1 | Start a program with `cmd_data` |
| cmd_erase | input | 1 | Start an erase of `cmd_sector` |
| cmd_suspend | input | 1 | Suspend the running erase |
| cmd_resume | input | 1 | Resume a suspended erase |
| cmd_sector | input | SW | Sector for an erase start |
| cmd_data | input | DW | Word loaded for a program |
| rd_stb | input | 1 | Read strobe, one read per high cycle |
| rd_sector | input | SW | Sector addressed by the read |
| arr_data | input | DW | Array word for the addressed location |
| rd_data | output | DW | Registered read result |
| rdy_bsy_n | output | 1 | Open-drain ready/busy: 0 or high-impedance |

## Verification
A read strobe can fall on the same edge where the duration counter expires. Bit 6 must then invert one last time, and the next read must already return true array data with the busy line released. The bench starts a program and times a read so that it is captured one edge before expiry, which places its falling strobe on the expiry edge. It then checks the status word from that read, the released line, and a following read that must match the array word exactly.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2,
    ST_SUSP  = 2'd3
  } op_state_t;
endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic [CW-1:0] remain,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign remain = cnt;
  assign zero   = (cnt == '0);
endmodule

// File: rtl/flash_op_fsm.sv
module flash_op_fsm
  import flash_status_pkg::*;
#(
  parameter int DW           = 16,
  parameter int SW           = 4,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 60,
  parameter int CW           = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_prog,
  input  logic          cmd_erase,
  input  logic          cmd_suspend,
  input  logic          cmd_resume,
  input  logic [SW-1:0] cmd_sector,
  input  logic [DW-1:0] cmd_data,
  input  logic          tmr_zero,
  input  logic [CW-1:0] tmr_remain,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_load_val,
  output logic          tmr_tick,
  output op_state_t     state,
  output logic [DW-1:0] prog_word,
  output logic [SW-1:0] erase_sec
);
  localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

  logic idle_start;
  assign idle_start   = (state == ST_IDLE) && (cmd_prog || cmd_erase);
  assign tmr_load     = idle_start;
  assign tmr_load_val = cmd_prog ? PROG_LOAD : ERASE_LOAD;
  assign tmr_tick     = (state == ST_PROG) || (state == ST_ERASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      prog_word <= '0;
      erase_sec <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmd_prog) begin
            state     <= ST_PROG;
            prog_word <= cmd_data;
          end else if (cmd_erase) begin
            state     <= ST_ERASE;
            erase_sec <= cmd_sector;
          end
        end
        ST_PROG:  if (tmr_zero) state <= ST_IDLE;
        ST_ERASE: begin
          if (tmr_zero)         state <= ST_IDLE;
          else if (cmd_suspend) state <= ST_SUSP;
        end
        ST_SUSP:  if (cmd_resume) state <= ST_ERASE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assert_susp_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SUSP && $past(state) != ST_SUSP) |-> $past(state) == ST_ERASE);

  assert_time_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SUSP && $past(state) == ST_SUSP) |-> $stable(tmr_remain));

  assert_word_kept_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(state) != ST_IDLE) |-> ($stable(prog_word) && $stable(erase_sec)));
endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
  import flash_status_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  op_state_t     state,
  input  logic [DW-1:0] prog_word,
  input  logic [SW-1:0] erase_sec,
  input  logic          rd_stb,
  input  logic [SW-1:0] rd_sector,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data
);
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int SUSP_BIT = 2;

  logic          rd_q, rd_fall, busy, hit_q;
  logic          tog_run, tog_susp;
  logic [DW-1:0] word;

  assign busy    = (state == ST_PROG) || (state == ST_ERASE);
  assign rd_fall = rd_q && !rd_stb;

  always_comb begin
    word = '0;
    unique case (state)
      ST_PROG: begin
        word[POLL_BIT] = ~prog_word[POLL_BIT];
        word[TOG_BIT]  = tog_run;
      end
      ST_ERASE: word[TOG_BIT] = tog_run;
      ST_SUSP: begin
        if (rd_sector == erase_sec) word[SUSP_BIT] = tog_susp;
        else                        word = arr_data;
      end
      default: word = arr_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= 1'b0;
      hit_q    <= 1'b0;
      tog_run  <= 1'b0;
      tog_susp <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_q <= rd_stb;
      if (rd_stb) begin
        rd_data <= word;
        hit_q   <= (rd_sector == erase_sec);
      end
      if (rd_fall && busy)                      tog_run  <= ~tog_run;
      if (rd_fall && state == ST_SUSP && hit_q) tog_susp <= ~tog_susp;
    end
  end

  assert_tog_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> $stable(tog_run));

  assert_susp_tog_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(state) != ST_SUSP) |-> $stable(tog_susp));
endmodule

// File: rtl/flash_status_rpt.sv
module flash_status_rpt
  import flash_status_pkg::*;
#(
  parameter int DW           = 16,
  parameter int SW           = 4,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_prog,
  input  logic          cmd_erase,
  input  logic          cmd_suspend,
  input  logic          cmd_resume,
  input  logic [SW-1:0] cmd_sector,
  input  logic [DW-1:0] cmd_data,
  input  logic          rd_stb,
  input  logic [SW-1:0] rd_sector,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          rdy_bsy_n
);
  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  op_state_t     state;
  logic [DW-1:0] prog_word;
  logic [SW-1:0] erase_sec;
  logic          tmr_load, tmr_tick, tmr_zero;
  logic [CW-1:0] tmr_load_val, tmr_remain;

  flash_op_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_load_val),
    .tick(tmr_tick), .remain(tmr_remain), .zero(tmr_zero)
  );

  flash_op_fsm #(
    .DW(DW), .SW(SW), .PROG_CYCLES(PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst(rst), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
    .cmd_sector(cmd_sector), .cmd_data(cmd_data),
    .tmr_zero(tmr_zero), .tmr_remain(tmr_remain), .tmr_load(tmr_load),
    .tmr_load_val(tmr_load_val), .tmr_tick(tmr_tick),
    .state(state), .prog_word(prog_word), .erase_sec(erase_sec)
  );

  flash_status_mux #(.DW(DW), .SW(SW)) u_mux (
    .clk(clk), .rst(rst), .state(state), .prog_word(prog_word),
    .erase_sec(erase_sec), .rd_stb(rd_stb), .rd_sector(rd_sector),
    .arr_data(arr_data), .rd_data(rd_data)
  );

  assign rdy_bsy_n = (state == ST_PROG || state == ST_ERASE) ? 1'b0 : 1'bz;

  assert_erase_poll_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_stb) && $past(state) == ST_ERASE) |-> rd_data[7] == 1'b0);

  assert_prog_poll_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_stb) && $past(state) == ST_PROG) |-> rd_data[7] == ~prog_word[7]);
endmodule

// File: tb/tb_flash_status_rpt.sv
module tb_flash_status_rpt;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int SW = 4;
  localparam int PC = 20;
  localparam int EC = 60;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_prog = 0, cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0;
  logic [SW-1:0] cmd_sector = '0, rd_sector = '0;
  logic [DW-1:0] cmd_data = '0, arr_data = '0;
  logic          rd_stb = 1'b0;
  logic [DW-1:0] rd_data;
  wire           rb_line;

  pullup (rb_line);

  flash_status_rpt #(.DW(DW), .SW(SW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
    .clk(clk), .rst(rst), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
    .cmd_sector(cmd_sector), .cmd_data(cmd_data), .rd_stb(rd_stb),
    .rd_sector(rd_sector), .arr_data(arr_data), .rd_data(rd_data),
    .rdy_bsy_n(rb_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  checks = 0, errors = 0;
  bit  done = 0;
  bit  m6 = 0, m2 = 0;
  bit  cnt_en = 0;
  int  lowcnt = 0;

  // {program word, array word} per vector
  localparam logic [31:0] VEC [4] = '{
    {16'h0080, 16'h1234}, {16'h007F, 16'hABCD},
    {16'hFFFF, 16'h0000}, {16'h5A00, 16'hFFFF}
  };

  always @(negedge clk) if (cnt_en && rb_line === 1'b0) lowcnt++;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input int kind, input logic [DW-1:0] d, input logic [SW-1:0] s);
    cmd_data = d; cmd_sector = s;
    case (kind)
      0: cmd_prog = 1;
      1: cmd_erase = 1;
      2: cmd_suspend = 1;
      default: cmd_resume = 1;
    endcase
    @(negedge clk);
    cmd_prog = 0; cmd_erase = 0; cmd_suspend = 0; cmd_resume = 0;
  endtask

  task automatic rd(input logic [SW-1:0] s, input logic [DW-1:0] a, output logic [DW-1:0] q);
    rd_stb = 1; rd_sector = s; arr_data = a;
    @(negedge clk);
    q = rd_data;
    rd_stb = 0;
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] busy_word(bit prog, logic [DW-1:0] pw, bit t6);
    logic [DW-1:0] w = '0;
    w[7] = prog ? ~pw[7] : 1'b0;
    w[6] = t6;
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] q;
    logic [DW-1:0] pw, aw;
    repeat (3) @(negedge clk);
    chk("R1 reset data", rd_data, '0);
    chk("R1 reset line", {15'd0, rb_line}, 16'd1);
    rst = 0;
    @(negedge clk);
    chk("R1 idle line", {15'd0, rb_line}, 16'd1);

    // vector walk: program status, toggle, completion
    for (int i = 0; i < 4; i++) begin
      pw = VEC[i][31:16]; aw = VEC[i][15:0];
      pulse(0, pw, '0);
      rd(4'd1, aw, q); chk("R2 R4 first poll", q, busy_word(1, pw, m6)); m6 = ~m6;
      rd(4'd1, aw, q); chk("R2 R4 second poll", q, busy_word(1, pw, m6)); m6 = ~m6;
      repeat (PC) @(negedge clk);
      chk("R5 released", {15'd0, rb_line}, 16'd1);
      rd(4'd1, aw, q); chk("R6 true data", q, aw);
      rd(4'd1, ~aw, q); chk("R6 true data again", q, ~aw);
    end

    // R5 exact program duration
    pulse(0, 16'h0000, '0);
    chk("R5 low at start", {15'd0, rb_line}, 16'd0);
    repeat (PC-1) @(negedge clk);
    chk("R5 low at last cycle", {15'd0, rb_line}, 16'd0);
    @(negedge clk);
    chk("R5 released after count", {15'd0, rb_line}, 16'd1);

    // erase with suspend/resume, duration counted
    lowcnt = 0; cnt_en = 1;
    pulse(1, '0, 4'd3);
    rd(4'd3, 16'h7777, q); chk("R3 R4 erase poll", q, busy_word(0, '0, m6)); m6 = ~m6;
    pulse(0, 16'h0000, '0);
    rd(4'd3, 16'h7777, q); chk("R10 start ignored while erasing", q, busy_word(0, '0, m6)); m6 = ~m6;
    pulse(2, '0, '0);
    chk("R5 released in suspend", {15'd0, rb_line}, 16'd1);
    rd(4'd3, 16'h7777, q); chk("R7 suspended sector", q, {13'd0, m2, 2'd0}); m2 = ~m2;
    rd(4'd3, 16'h7777, q); chk("R7 suspended sector toggles", q, {13'd0, m2, 2'd0}); m2 = ~m2;
    rd(4'd5, 16'hBEEF, q); chk("R8 other sector data", q, 16'hBEEF);
    rd(4'd3, 16'h7777, q); chk("R8 bit2 sequence kept", q, {13'd0, m2, 2'd0}); m2 = ~m2;
    pulse(3, '0, '0);
    rd(4'd3, 16'h7777, q); chk("R3 poll after resume", q, busy_word(0, '0, m6)); m6 = ~m6;
    repeat (EC + 4) @(negedge clk);
    cnt_en = 0;
    chk("R9 total busy cycles", 16'(lowcnt), 16'(EC));
    rd(4'd3, 16'h4321, q); chk("R6 data after erase", q, 16'h4321);

    // R10 suspend/resume ignored while idle
    pulse(2, '0, '0);
    pulse(3, '0, '0);
    chk("R10 idle line", {15'd0, rb_line}, 16'd1);
    rd(4'd3, 16'h0F0F, q); chk("R10 idle data", q, 16'h0F0F);

    // read whose strobe falls on the expiry edge
    pulse(0, 16'h0000, '0);
    repeat (PC-2) @(negedge clk);
    rd(4'd2, 16'h2468, q); chk("R4 poll at expiry", q, busy_word(1, 16'h0000, m6)); m6 = ~m6;
    chk("R5 released at expiry", {15'd0, rb_line}, 16'd1);
    rd(4'd2, 16'h2468, q); chk("R6 data right after expiry", q, 16'h2468);

    // next program: bit 6 sequence continues
    pulse(0, 16'h0080, '0);
    rd(4'd2, 16'h0, q); chk("R4 sequence continues", q, busy_word(1, 16'h0080, m6)); m6 = ~m6;
    repeat (PC) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule